// File: doc/BRIEF.md
# Multiply-Based Byte Rotator

This block rotates an 8-bit byte to the left by a 3-bit amount in a single clock cycle. Bits pushed out of the most significant end come back in at the least significant end. Instead of building a tree of multiplexers, the block does the rotation as one multiplication. The byte is repeated into a 16-bit operand. That operand is multiplied by a power of two selected by the shift amount. The middle byte of the product is the rotated value.

A small binary-to-one-hot encoder inside the block turns the 3-bit amount into the 8-bit power-of-two multiplier. The multiply is written behaviourally, so synthesis can map it onto a hard multiplier or onto general logic. Data and amount are captured on the same rising edge, and the rotated byte appears on the registered output right after that edge.

Top module: `mulrot8`

## Requirements
- R1: On each rising edge with `rst` low, `dout` takes the left rotation of the `din` present at that edge by the `amt` present at that edge. Bit i of `din` lands at bit (i+amt) mod 8. Between edges, `dout` holds its value.
- R2: Bits shifted past bit 7 wrap into the low end: the lowest `amt` bits of the result equal the highest `amt` bits of the input. For example, 8'b1111_0000 rotated by 3 gives 8'b1000_0111.
- R3: An amount of 0 passes `din` to `dout` unchanged after one edge.
- R4: When `rst` is high at a rising edge, `dout` becomes 8'h00 whatever `din` and `amt` are. Reset is synchronous and active high.
- R5: The internal multiplier code is one-hot, with bit number equal to `amt`: amount 0 gives 8'b0000_0001, amount 1 gives 8'b0000_0010, and so on up to amount 7, which gives 8'b1000_0000.
- R6: The internal 16-bit operand carries `din` in bits [15:8] and again in bits [7:0]. Above the operand, the product's low byte [7:0] equals `din` shifted left with zero fill. The product's top byte [23:16] equals the bits that overflow the upper copy.
- R7: The number of set bits in `dout` equals the number of set bits in the `din` captured at the previous edge.
- R8: An amount of 7 is the same as rotating right by one position: the old bit 0 ends up in bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| din | input | 8 | Byte to rotate |
| amt | input | 3 | Left-rotate amount, binary 0 to 7 |
| dout | output | 8 | Registered rotated byte |

## Verification
The only state in this block is the output register. Every other fault sits in combinational logic and shows up at `dout` on the edge straight after the bad input is applied.

Each fault type has its own signature at `dout`:
- A wrong bit in the one-hot code gives a result rotated by the wrong amount, or a byte with lost or doubled bits, which changes the population count.
- A missing or misplaced operand copy clears the wrapped low bits.
- Taking the wrong product window shifts the whole result by a byte.

A sweep of all 256 byte values at every amount shows each of these faults within one cycle of the input that triggers it.

// File: rtl/mulrot_pkg.sv
package mulrot_pkg;

  localparam int unsigned ROT_W   = 8;
  localparam int unsigned AMT_W   = $clog2(ROT_W);
  localparam int unsigned COPIES  = 2;
  localparam int unsigned OPND_W  = ROT_W * COPIES;
  localparam int unsigned PROD_W  = OPND_W + ROT_W;

  typedef logic [ROT_W-1:0]  byte_t;
  typedef logic [AMT_W-1:0]  amt_t;
  typedef logic [OPND_W-1:0] opnd_t;
  typedef logic [PROD_W-1:0] prod_t;

  // One-hot power of two for a binary amount.
  function automatic byte_t code_of(input amt_t a);
    byte_t c;
    c = '0;
    c[a] = 1'b1;
    return c;
  endfunction

  // Repeat a byte to fill the operand.
  function automatic opnd_t widen(input byte_t b);
    return {COPIES{b}};
  endfunction

  // Window of the product holding the rotated byte.
  function automatic byte_t window(input prod_t p);
    return p[2*ROT_W-1:ROT_W];
  endfunction

endpackage

// File: rtl/mulrot_onehot_enc.sv
module mulrot_onehot_enc #(
  parameter int unsigned N_OUT = 8,
  localparam int unsigned N_IN = $clog2(N_OUT)
) (
  input  logic [N_IN-1:0]  amt_bin,
  output logic [N_OUT-1:0] amt_code
);

  for (genvar g = 0; g < N_OUT; g++) begin : g_dec
    assign amt_code[g] = (amt_bin == N_IN'(g));
  end

endmodule

// File: rtl/mulrot_operand.sv
module mulrot_operand #(
  parameter int unsigned SEG_W  = 8,
  parameter int unsigned N_COPY = 2,
  localparam int unsigned OUT_W = SEG_W * N_COPY
) (
  input  logic [SEG_W-1:0] seg_in,
  output logic [OUT_W-1:0] opnd_out
);

  for (genvar g = 0; g < N_COPY; g++) begin : g_copy
    assign opnd_out[g*SEG_W +: SEG_W] = seg_in;
  end

endmodule

// File: rtl/mulrot_mul.sv
module mulrot_mul #(
  parameter int unsigned A_W = 16,
  parameter int unsigned B_W = 8,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic [A_W-1:0] mul_a,
  input  logic [B_W-1:0] mul_b,
  output logic [P_W-1:0] mul_p
);

  // Behavioural unsigned multiply; synthesis chooses the structure.
  always_comb begin
    mul_p = P_W'(mul_a) * P_W'(mul_b);
  end

endmodule

// File: rtl/mulrot8.sv
module mulrot8
  import mulrot_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ROT_W-1:0] din,
  input  logic [AMT_W-1:0] amt,
  output logic [ROT_W-1:0] dout
);

  byte_t shift_code;
  opnd_t operand;
  prod_t product;
  byte_t rot_next;
  byte_t dout_q;

  mulrot_onehot_enc #(.N_OUT(ROT_W)) u_enc (
    .amt_bin  (amt),
    .amt_code (shift_code)
  );

  mulrot_operand #(.SEG_W(ROT_W), .N_COPY(COPIES)) u_opnd (
    .seg_in   (din),
    .opnd_out (operand)
  );

  mulrot_mul #(.A_W(OPND_W), .B_W(ROT_W)) u_mul (
    .mul_a (operand),
    .mul_b (shift_code),
    .mul_p (product)
  );

  assign rot_next = window(product);

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else     dout_q <= rot_next;
  end

  assign dout = dout_q;

endmodule

// File: rtl/mulrot8_chk.sv
module mulrot8_chk
  import mulrot_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input byte_t din,
  input amt_t  amt,
  input byte_t shift_code,
  input opnd_t operand,
  input prod_t product,
  input byte_t dout
);

  function automatic byte_t ref_rotl(input byte_t d, input amt_t a);
    byte_t r;
    for (int i = 0; i < int'(ROT_W); i++) r[(i + int'(a)) % int'(ROT_W)] = d[i];
    return r;
  endfunction

  function automatic byte_t top_spill(input byte_t d, input amt_t a);
    byte_t r;
    r = '0;
    for (int i = 0; i < int'(a); i++) r[i] = d[int'(ROT_W) - int'(a) + i];
    return r;
  endfunction

  assert_rotate_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dout == ref_rotl($past(din), $past(amt)));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((dout & ((8'd1 << $past(amt)) - 8'd1)) == top_spill($past(din), $past(amt))));

  assert_zero_shift_R3: assert property (@(posedge clk) disable iff (rst)
    amt == '0 |=> dout == $past(din));

  assert_reset_clear_R4: assert property (@(posedge clk)
    rst |=> dout == '0);

  assert_onehot_code_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(shift_code) == 1 && shift_code[amt]);

  assert_operand_dup_R6: assert property (@(posedge clk) disable iff (rst)
    operand[OPND_W-1:ROT_W] == din && operand[ROT_W-1:0] == din);

  assert_product_edges_R6: assert property (@(posedge clk) disable iff (rst)
    product[ROT_W-1:0] == byte_t'(din << amt) &&
    product[PROD_W-1:OPND_W] == top_spill(din, amt));

  assert_popcount_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(dout) == $countones($past(din)));

  assert_rot_right_one_R8: assert property (@(posedge clk) disable iff (rst)
    amt == amt_t'(ROT_W - 1) |=> dout == {$past(din[0]), $past(din[ROT_W-1:1])});

endmodule

bind mulrot8 mulrot8_chk u_mulrot8_chk (
  .clk        (clk),
  .rst        (rst),
  .din        (din),
  .amt        (amt),
  .shift_code (shift_code),
  .operand    (operand),
  .product    (product),
  .dout       (dout)
);

// File: tb/test_mulrot8.sv
module test_mulrot8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h00;
  logic [2:0] amt = 3'd0;
  logic [7:0] dout;

  int n_total = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  mulrot8 i_mulrot8 (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .amt  (amt),
    .dout (dout)
  );

  function automatic logic [7:0] exp_rot(input int d, input int a);
    int v;
    v = (d * (1 << a));
    return 8'((v % 256) + (v / 256));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Apply at a falling edge, let one rising edge pass, sample at next falling edge.
  task automatic apply(input logic [7:0] d, input logic [2:0] a, input logic r);
    @(negedge clk);
    din = d; amt = a; rst = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    // R4: reset clears even with nonzero data
    apply(8'hA5, 3'd3, 1'b1);
    check("R4 reset state", dout, 8'h00);
    apply(8'hFF, 3'd7, 1'b1);
    check("R4 reset over data", dout, 8'h00);

    // R2: spec example
    apply(8'hF0, 3'd3, 1'b0);
    check("R2 F0 rot 3", dout, 8'h87);

    // R1: output holds until the next rising edge
    @(negedge clk);
    din = 8'h01; amt = 3'd1;
    #2 check("R1 held between edges", dout, 8'h87);
    @(negedge clk);
    check("R1 one edge latency", dout, 8'h02);

    // R3: zero amount passthrough
    for (int d = 0; d < 256; d += 17) begin
      apply(8'(d), 3'd0, 1'b0);
      check("R3 zero shift", dout, 8'(d));
    end

    // R8: amount 7 equals rotate right by one
    apply(8'h01, 3'd7, 1'b0);
    check("R8 bit0 to bit7", dout, 8'h80);
    apply(8'h96, 3'd7, 1'b0);
    check("R8 rot right", dout, 8'h4B);

    // R5/R6: single bits at each amount expose code and operand faults
    for (int a = 0; a < 8; a++) begin
      apply(8'h80, 3'(a), 1'b0);
      check("R5 R6 msb wrap", dout, 8'(1 << ((7 + a) % 8)));
    end

    // R1 R2 R7: exhaustive sweep
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 256; d++) begin
        apply(8'(d), 3'(a), 1'b0);
        check("R1 R2 R7 sweep", dout, exp_rot(d, a));
      end
    end

    // R4: reset mid-stream
    apply(8'h3C, 3'd2, 1'b1);
    check("R4 reset mid-stream", dout, 8'h00);
    apply(8'h3C, 3'd2, 1'b0);
    check("R1 after reset", dout, 8'hF0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule